// File: doc/BRIEF.md
# Conversion Result Holding Register with Paired-Byte Read Interlock

This block keeps the most recent converter result and exposes it to an 8-bit bus as two bytes, a low byte and a high byte. The pair can be right-justified, with the result sitting in the lowest bits, or left-justified, with the most significant result bits filling the high byte. Software reads the low byte first and the high byte second. The first of those reads freezes the stored value, so both bytes always come from one conversion.

While the value is frozen, new results from the sequencer are thrown away rather than stored. A sticky flag records that at least one result was thrown away. Reading the high byte lifts the freeze and clears that flag. The stored bits are kept exactly as the converter delivered them. This also covers results from differential inputs, which arrive in one's-complement form. The justification choice is applied when the bytes are read, not when they are stored.

Top module: `adc_result_hold`

## Requirements
- R1: After reset the stored result is zero, both bytes read zero, and the lost flag is low. A result strobe that arrives while the pair is unlocked replaces the stored result at the next clock edge.
- R2: A cycle with `rd_lo_i` high and `rd_hi_i` low locks the pair. A result strobe in that same cycle, or in any later cycle while the pair stays locked, leaves the stored result unchanged.
- R3: A cycle with `rd_hi_i` high unlocks the pair. A result strobe in that same cycle is stored, as if the pair were unlocked.
- R4: A result strobe that R2 discards sets `lost_o` at the next edge. `lost_o` then stays high until R5 clears it.
- R5: A cycle with `rd_hi_i` high clears `lost_o` at the next edge.
- R6: With `left_just_i`=0, `lo_data_o` holds result bits 7:0. `hi_data_o` bits 1:0 hold result bits 9:8, and `hi_data_o` bits 7:2 read zero.
- R7: With `left_just_i`=1, `hi_data_o` holds result bits 9:2. `lo_data_o` bits 7:6 hold result bits 1:0, and `lo_data_o` bits 5:0 read zero.
- R8: `left_just_i` acts at read time. Changing it changes the byte outputs in the same cycle without any new result, and the stored result is unchanged.
- R9: The result is stored verbatim, with no sign extension. A one's-complement value with bit 9 set still gives zero in every unused bit of the pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid_i | input | 1 | One-cycle strobe: a new result is present |
| res_value_i | input | 10 | New conversion result |
| left_just_i | input | 1 | 0 = right-justified pair, 1 = left-justified pair |
| rd_lo_i | input | 1 | Low-byte read strobe |
| rd_hi_i | input | 1 | High-byte read strobe |
| lo_data_o | output | 8 | Low byte read data |
| hi_data_o | output | 8 | High byte read data |
| lost_o | output | 1 | Sticky flag: a result was discarded under the lock |

## Verification
The assertions assume that every input is a defined 0 or 1 at each clock edge. They also assume that `res_valid_i` and the read strobes may arrive in any combination, including `rd_lo_i` and `rd_hi_i` together, in which case the high read wins. The stimulus drives every input on the falling edge, so it never changes near the sampling edge. It draws the strobes independently with a fixed seed, so locked and unlocked cycles, drops, and same-cycle read-and-result collisions all occur. Directed sequences add negative one's-complement codes and justification flips while the pair is locked.

// File: rtl/adc_result_pkg.sv
package adc_result_pkg;

    // Interlock state: pair frozen, and a result was discarded
    typedef struct packed {
        logic lock;
        logic lost;
    } lock_st_t;

endpackage

// File: rtl/adc_res_justify.sv
module adc_res_justify #(
    parameter int RES_W = 10,
    parameter int BUS_W = 8
) (
    input  logic [RES_W-1:0] res_i,
    input  logic             left_i,
    output logic [BUS_W-1:0] lo_o,
    output logic [BUS_W-1:0] hi_o
);
    localparam int PAIR_W = 2 * BUS_W;
    localparam int PAD_W  = PAIR_W - RES_W;

    logic [PAIR_W-1:0] right_pair;
    logic [PAIR_W-1:0] left_pair;
    logic [PAIR_W-1:0] pair;

    generate
        if (PAD_W > 0) begin : g_pad
            assign right_pair = {{PAD_W{1'b0}}, res_i};
            assign left_pair  = {res_i, {PAD_W{1'b0}}};
        end else begin : g_full
            assign right_pair = res_i;
            assign left_pair  = res_i;
        end
    endgenerate

    always_comb begin
        pair = left_i ? left_pair : right_pair;
        lo_o = pair[BUS_W-1:0];
        hi_o = pair[PAIR_W-1:BUS_W];
    end

    // R7: low padding reads zero when left-justified
    always_comb begin
        if (PAD_W > 0 && PAD_W <= BUS_W && left_i) begin
            p_left_pad_zero_r7: assert ((lo_o & ((BUS_W'(1) << PAD_W) - BUS_W'(1))) == '0);
        end
    end

endmodule

// File: rtl/adc_res_lock_ctl.sv
module adc_res_lock_ctl
    import adc_result_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic valid_i,
    input  logic rd_lo_i,
    input  logic rd_hi_i,
    output logic store_o,
    output logic lock_o,
    output logic lost_o
);
    lock_st_t st_q, st_d;
    logic     blocked;

    always_comb begin
        st_d    = st_q;
        blocked = (st_q.lock | rd_lo_i) & ~rd_hi_i;
        store_o = valid_i & ~blocked;
        if (rd_hi_i)      st_d.lock = 1'b0;
        else if (rd_lo_i) st_d.lock = 1'b1;
        if (valid_i && blocked) st_d.lost = 1'b1;
        else if (rd_hi_i)       st_d.lost = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lock_o = st_q.lock;
    assign lost_o = st_q.lost;

    // R4: a drop under the lock raises the flag
    p_drop_sets_lost_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (lock_o || rd_lo_i) && !rd_hi_i) |=> lost_o);
    // R4: flag is sticky until a high read
    p_lost_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lost_o && !rd_hi_i) |=> lost_o);
    // R5: high read clears the flag
    p_hi_clears_lost_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi_i |=> !lost_o);
    // R2: low read alone engages the lock
    p_lo_locks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo_i && !rd_hi_i) |=> lock_o);
    // R3: high read releases the lock
    p_hi_unlocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi_i |=> !lock_o);

endmodule

// File: rtl/adc_result_hold.sv
module adc_result_hold #(
    parameter int RES_W = 10,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             res_valid_i,
    input  logic [RES_W-1:0] res_value_i,
    input  logic             left_just_i,
    input  logic             rd_lo_i,
    input  logic             rd_hi_i,
    output logic [BUS_W-1:0] lo_data_o,
    output logic [BUS_W-1:0] hi_data_o,
    output logic             lost_o
);
    logic [RES_W-1:0] res_q, res_d;
    logic             store;
    logic             locked;

    adc_res_lock_ctl u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (res_valid_i),
        .rd_lo_i (rd_lo_i),
        .rd_hi_i (rd_hi_i),
        .store_o (store),
        .lock_o  (locked),
        .lost_o  (lost_o)
    );

    always_comb begin
        res_d = res_q;
        if (store) res_d = res_value_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    adc_res_justify #(
        .RES_W (RES_W),
        .BUS_W (BUS_W)
    ) u_just (
        .res_i  (res_q),
        .left_i (left_just_i),
        .lo_o   (lo_data_o),
        .hi_o   (hi_data_o)
    );

    // R1, R3: an accepted strobe lands in the register
    p_store_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_i && ((!locked && !rd_lo_i) || rd_hi_i)) |=> (res_q == $past(res_value_i)));
    // R2: the frozen pair does not move
    p_locked_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((locked || rd_lo_i) && !rd_hi_i) |=> $stable(res_q));

endmodule

// File: tb/adc_result_hold_tb.sv
module adc_result_hold_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       res_valid_i = 1'b0;
    logic [9:0] res_value_i = '0;
    logic       left_just_i = 1'b0;
    logic       rd_lo_i = 1'b0;
    logic       rd_hi_i = 1'b0;
    logic [7:0] lo_data_o, hi_data_o;
    logic       lost_o;

    int errors = 0;
    int checks = 0;

    logic [9:0] m_res  = '0;
    logic       m_lock = 1'b0;
    logic       m_lost = 1'b0;

    always #10 clk = ~clk;

    adc_result_hold u_dut (
        .clk(clk), .rst_n(rst_n), .res_valid_i(res_valid_i), .res_value_i(res_value_i),
        .left_just_i(left_just_i), .rd_lo_i(rd_lo_i), .rd_hi_i(rd_hi_i),
        .lo_data_o(lo_data_o), .hi_data_o(hi_data_o), .lost_o(lost_o)
    );

    function automatic logic [15:0] exp_pair(input logic [9:0] v, input logic lj);
        return lj ? {v, 6'b0} : {6'b0, v};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cycle(input logic v, input logic [9:0] val, input logic lj,
                         input logic lo, input logic hi, input string tag);
        logic [15:0] p;
        logic        blocked;
        @(negedge clk);
        res_valid_i = v; res_value_i = val; left_just_i = lj; rd_lo_i = lo; rd_hi_i = hi;
        #1;
        p = exp_pair(m_res, lj);
        check({tag, (lj ? " R7" : " R6"), " pair"}, {hi_data_o, lo_data_o}, p);
        check({tag, " R4 R5 lost"}, lost_o, m_lost);
        blocked = (m_lock | lo) & ~hi;
        if (v && !blocked) m_res = val;
        if (v && blocked) m_lost = 1'b1;
        else if (hi) m_lost = 1'b0;
        if (hi) m_lock = 1'b0;
        else if (lo) m_lock = 1'b1;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'hADC0_1234);
        #35;
        check("R1 reset lo", lo_data_o, 0);
        check("R1 reset hi", hi_data_o, 0);
        check("R1 reset lost", lost_o, 0);
        rst_n = 1'b1;

        // R1: store when unlocked
        cycle(1, 10'h2A5, 0, 0, 0, "R1 store");
        cycle(0, 10'h000, 0, 0, 0, "R1 R6 readback");
        // R8: flip justification with no new result
        cycle(0, 10'h000, 1, 0, 0, "R8 flip left");
        cycle(0, 10'h000, 0, 0, 0, "R8 flip right");
        // R2: low read with result in same cycle is dropped
        cycle(1, 10'h155, 0, 1, 0, "R2 lo plus result");
        cycle(1, 10'h0F0, 1, 0, 0, "R2 R8 locked");
        cycle(0, 10'h000, 0, 0, 0, "R2 R4 still frozen");
        // R3: high read with a result in the same cycle is stored
        cycle(1, 10'h3FE, 0, 0, 1, "R3 hi plus result");
        cycle(0, 10'h000, 0, 0, 0, "R3 R5 R9 after release");
        cycle(0, 10'h000, 1, 0, 0, "R9 R7 negative code");
        // R5 with both strobes together: high wins
        cycle(1, 10'h201, 0, 1, 1, "R3 both strobes");
        cycle(0, 10'h000, 0, 0, 0, "R3 R9 both result");

        for (int i = 0; i < 3000; i++) begin
            cycle(($urandom % 10) < 3, 10'($urandom), 1'($urandom),
                  ($urandom % 10) < 2, ($urandom % 10) < 2, "random");
        end
        cycle(0, 10'h000, 0, 0, 0, "final");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule